// File: doc/BRIEF.md
# Overload Timeout and Runaway Period Stretch

This block supervises a fixed-frequency, peak-current-controlled converter while it is overloaded. A flag from the control loop reports that the sense demand lies above the overpower threshold. For as long as that flag stays high without a break, a timer runs on a slow tick. If the overload lasts past the timeout, the block raises a fault that stays set until reset. A single low cycle of the overload flag returns the timer to zero.

A second function guards against peak-current runaway during an output short. The guard is armed only while two conditions hold together: the overload flag is high, and the sampled output voltage is reported below half of the overvoltage level. On every switching-cycle strobe, the block decides the length of the coming period. An armed guard that sees an early-peak flag (peak level reached within about 1 us of turn-on) selects the long period, roughly 28 us in place of 7.7 us. Any other case selects the normal period.

While the guard is armed, the overload timeout is cut to half. This limits the energy the supply takes in during a sustained short. The oscillator, comparators and current sensing sit outside the block.

Top module: `opp_sc_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `fault_o` is 0 and `stretch_o` is 0 (normal period).
- R2: The timer advances one step every `TICK_DIV` clocks, but only while `ovl_i` stays high. A clock edge that samples `ovl_i` low returns the count to zero at once. Any earlier progress therefore gives no credit toward the timeout.
- R3: With the guard not armed, an unbroken overload sets `fault_o` at the clock edge numbered `OPP_TICKS*TICK_DIV+1`, counted from the first edge that samples `ovl_i` high. It is not set one edge earlier.
- R4: The guard is armed while `ovl_i` and `vout_low_i` are both high. While it is armed, the timeout limit is `OPP_TICKS/2` ticks (at least 1). An armed, unbroken overload therefore sets `fault_o` at edge `(OPP_TICKS/2)*TICK_DIV+1`.
- R5: Once set, `fault_o` stays 1 whatever the inputs do, until `rst` is asserted.
- R6: At a clock edge that samples `cyc_i` high, `stretch_o` becomes 1 when the guard is armed and `early_pk_i` is high. Otherwise it becomes 0. The value 1 selects the stretched period and 0 selects the normal period.
- R7: Between strobes, `stretch_o` holds its value. `early_pk_i`, `ovl_i` and `vout_low_i` have no effect on it at edges where `cyc_i` is low.
- R8: An early peak never stretches the period while the guard is disarmed, that is, while `vout_low_i` is low or `ovl_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset, clears fault and timer |
| ovl_i | input | 1 | Sense demand above the overpower threshold |
| vout_low_i | input | 1 | Sampled output below half the overvoltage level |
| early_pk_i | input | 1 | Peak level reached within the early window this cycle |
| cyc_i | input | 1 | One-clock strobe per switching cycle |
| fault_o | output | 1 | Sticky overpower timeout fault |
| stretch_o | output | 1 | Period select for the next cycle: 1 stretched, 0 normal |

## Verification
The bench builds the block with `TICK_DIV=4` and `OPP_TICKS=20`. With these values the full timeout lands at edge 81 and the halved timeout at edge 41. Both windows fit within a few hundred cycles, so the directed cases can step exactly across each boundary. The short window also lets random runs of overload, arming changes, resets and strobes reach the fault many times, and break the count partway through.

// File: rtl/opp_sc_pkg.sv
package opp_sc_pkg;

    // Flags sampled from the analogue front end each clock
    typedef struct packed {
        logic overload;
        logic vout_low;
        logic early_peak;
        logic strobe;
    } sense_t;

    // Period select toward the oscillator
    typedef enum logic {
        PER_NORMAL  = 1'b0,
        PER_STRETCH = 1'b1
    } period_e;

    // Tick limit used while the short-circuit guard is armed
    function automatic int unsigned sc_limit(input int unsigned full);
        return (full / 2 > 0) ? full / 2 : 1;
    endfunction

    function automatic int unsigned width_of(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/opp_sc_prescale.sv
module opp_sc_prescale #(
    parameter int unsigned TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned PRE_W = opp_sc_pkg::width_of(TICK_DIV - 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick = run && (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/opp_sc_timer.sv
module opp_sc_timer #(
    parameter int unsigned OPP_TICKS = 170,
    parameter int unsigned CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             overload,
    input  logic             armed,
    input  logic             tick,
    output logic             fault,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LIM_FULL = CNT_W'(OPP_TICKS);
    localparam logic [CNT_W-1:0] LIM_SC   = CNT_W'(opp_sc_pkg::sc_limit(OPP_TICKS));

    logic [CNT_W-1:0] cnt_q;
    logic             fault_q;
    logic [CNT_W-1:0] limit;
    logic             expired;

    assign limit   = armed ? LIM_SC : LIM_FULL;
    assign expired = overload && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!overload) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < LIM_FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
        end else if (expired) begin
            fault_q <= 1'b1;
        end
    end

    assign fault = fault_q;
    assign count = cnt_q;
endmodule

// File: rtl/opp_sc_stretch.sv
module opp_sc_stretch (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe,
    input  logic                armed,
    input  logic                early_peak,
    output opp_sc_pkg::period_e sel
);
    import opp_sc_pkg::*;

    period_e sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= PER_NORMAL;
        end else if (strobe) begin
            sel_q <= (armed && early_peak) ? PER_STRETCH : PER_NORMAL;
        end
    end

    assign sel = sel_q;
endmodule

// File: rtl/opp_sc_guard.sv
module opp_sc_guard #(
    parameter int unsigned TICK_DIV  = 1000,
    parameter int unsigned OPP_TICKS = 170
) (
    input  logic clk,
    input  logic rst,
    input  logic ovl_i,
    input  logic vout_low_i,
    input  logic early_pk_i,
    input  logic cyc_i,
    output logic fault_o,
    output logic stretch_o
);
    import opp_sc_pkg::*;

    localparam int unsigned CNT_W = width_of(OPP_TICKS);

    sense_t           sense;
    logic             armed;
    logic             tick;
    logic             fault;
    logic [CNT_W-1:0] tmr_cnt;
    period_e          sel;

    assign sense = '{overload: ovl_i, vout_low: vout_low_i,
                     early_peak: early_pk_i, strobe: cyc_i};

    // Guard armed only while overloaded with the output collapsed
    assign armed = sense.overload && sense.vout_low;

    opp_sc_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (sense.overload && !fault),
        .tick (tick)
    );

    opp_sc_timer #(.OPP_TICKS(OPP_TICKS), .CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .overload (sense.overload),
        .armed    (armed),
        .tick     (tick),
        .fault    (fault),
        .count    (tmr_cnt)
    );

    opp_sc_stretch u_str (
        .clk        (clk),
        .rst        (rst),
        .strobe     (sense.strobe),
        .armed      (armed),
        .early_peak (sense.early_peak),
        .sel        (sel)
    );

    assign fault_o   = fault;
    assign stretch_o = (sel == PER_STRETCH);
endmodule

// File: rtl/opp_sc_guard_chk.sv
module opp_sc_guard_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ovl_i,
    input logic             vout_low_i,
    input logic             early_pk_i,
    input logic             cyc_i,
    input logic             fault_o,
    input logic             stretch_o,
    input logic [CNT_W-1:0] tmr_cnt
);
    a_r2_clear_on_drop: assert property (@(posedge clk) disable iff (rst)
        !ovl_i |=> (tmr_cnt == '0));

    a_r3_fault_needs_overload: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_o) |-> $past(ovl_i));

    a_r5_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> fault_o);

    a_r6_stretch_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(stretch_o) |-> $past(cyc_i && ovl_i && vout_low_i && early_pk_i));

    a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
        !cyc_i |=> $stable(stretch_o));
endmodule

bind opp_sc_guard opp_sc_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ovl_i      (ovl_i),
    .vout_low_i (vout_low_i),
    .early_pk_i (early_pk_i),
    .cyc_i      (cyc_i),
    .fault_o    (fault_o),
    .stretch_o  (stretch_o),
    .tmr_cnt    (tmr_cnt)
);

// File: tb/opp_sc_guard_test.sv
module opp_sc_guard_test;
    localparam int DIV  = 4;
    localparam int FULL = 20;
    localparam int HALF = FULL / 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, ovl = 1'b0, vlow = 1'b0, early = 1'b0, cyc = 1'b0;
    logic fault_o, stretch_o;

    opp_sc_guard #(.TICK_DIV(DIV), .OPP_TICKS(FULL)) uut (
        .clk(clk), .rst(rst), .ovl_i(ovl), .vout_low_i(vlow),
        .early_pk_i(early), .cyc_i(cyc), .fault_o(fault_o), .stretch_o(stretch_o)
    );

    int n_cmp = 0, n_bad = 0;
    string tag = "R1";

    // Reference model written from the requirements
    int m_pre = 0, m_cnt = 0;
    logic m_fault = 1'b0, m_str = 1'b0;

    function automatic int lim_of(input logic armed);
        return armed ? HALF : FULL;
    endfunction

    always @(posedge clk) begin
        logic armed, tick, nf;
        armed = ovl && vlow;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_fault = 1'b0; m_str = 1'b0;
        end else begin
            nf   = m_fault || (ovl && (m_cnt >= lim_of(armed)));
            tick = ovl && !m_fault && (m_pre == DIV - 1);
            if (!ovl) m_cnt = 0;
            else if (tick && m_cnt < FULL) m_cnt = m_cnt + 1;
            if (!ovl || m_fault || tick) m_pre = 0;
            else m_pre = m_pre + 1;
            m_fault = nf;
            if (cyc) m_str = armed && early;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic o, input logic v, input logic e, input logic c);
        ovl = o; vlow = v; early = e; cyc = c;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "fault_o(model)", fault_o, m_fault);
        chk(tag, "stretch_o(model)", stretch_o, m_str);
    endtask

    task automatic run(input int n, input logic o, input logic v);
        for (int i = 0; i < n; i++) step(o, v, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        tag = "R1";
        do_reset();
        chk("R1", "fault_o after reset", fault_o, 1'b0);
        chk("R1", "stretch_o after reset", stretch_o, 1'b0);

        // R3 full timeout boundary
        tag = "R3";
        run(FULL * DIV, 1'b1, 1'b0);
        chk("R3", "fault_o one edge early", fault_o, 1'b0);
        run(1, 1'b1, 1'b0);
        chk("R3", "fault_o at full limit", fault_o, 1'b1);

        // R5 sticky fault
        tag = "R5";
        run(7, 1'b0, 1'b1);
        chk("R5", "fault_o after overload drop", fault_o, 1'b1);
        do_reset();
        chk("R5", "fault_o cleared by reset", fault_o, 1'b0);

        // R4 halved timeout while armed
        tag = "R4";
        run(HALF * DIV, 1'b1, 1'b1);
        chk("R4", "fault_o one edge early", fault_o, 1'b0);
        run(1, 1'b1, 1'b1);
        chk("R4", "fault_o at halved limit", fault_o, 1'b1);
        do_reset();

        // R2 drop clears accumulated time
        tag = "R2";
        run(FULL * DIV - 4, 1'b1, 1'b0);
        run(1, 1'b0, 1'b0);
        run(FULL * DIV, 1'b1, 1'b0);
        chk("R2", "fault_o after restarted count", fault_o, 1'b0);
        run(1, 1'b1, 1'b0);
        chk("R2", "fault_o after full restarted count", fault_o, 1'b1);
        do_reset();

        // R6 stretch decision per strobe
        tag = "R6";
        step(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R6", "stretch_o armed early peak", stretch_o, 1'b1);
        // R7 inputs ignored between strobes
        tag = "R7";
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R7", "stretch_o held off-strobe", stretch_o, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        tag = "R6";
        step(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R6", "stretch_o back to normal", stretch_o, 1'b0);
        tag = "R7";
        step(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R7", "stretch_o not set off-strobe", stretch_o, 1'b0);

        // R8 disarmed guard
        tag = "R8";
        step(1'b1, 1'b0, 1'b1, 1'b1);
        chk("R8", "stretch_o vout not low", stretch_o, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R8", "stretch_o no overload", stretch_o, 1'b0);
        do_reset();

        // Random mix checked against the model (R2 R3 R4 R5 R6 R7 R8)
        tag = "R4 random";
        void'($urandom(32'd1234));
        begin
            logic o, v;
            o = 1'b1; v = 1'b0;
            for (int i = 0; i < 6000; i++) begin
                if ($urandom_range(0, 59) == 0) o = ~o;
                if ($urandom_range(0, 39) == 0) v = ~v;
                rst = ($urandom_range(0, 299) == 0);
                step(o, v, 1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0));
            end
            rst = 1'b0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule